// File: doc/BRIEF.md
# DRAM Refresh Burst Sequencer

This block turns periodic refresh requests into bursts of refresh bus transactions. Each accepted request starts a burst of between 1 and 64 transactions. Every transaction steps through three phases, T1, T2 and T3. Each phase lasts one base cycle plus its own programmable number of wait cycles, so slow memory can be refreshed without changing the request rate.

Two byte-wide control registers sit on a simple write port with a combinational read-back. The control register holds the enable bit and the burst size. The wait register holds the three wait counts. A request that arrives while a burst is running is remembered as a single pending flag and is served after the burst ends. Clearing the enable bit lets the current transaction finish and then stops the sequencer.

Top module: `rfsh_burst_seq`

## Requirements
- R1: After reset the control register (select 0) reads 0x00, the wait register (select 1) reads 0xFF, `busy_o` is low and `phase_o` is 0 (idle).
- R2: While control bit 7 (enable) is 0, requests are ignored: `busy_o` stays low and no transaction runs.
- R3: Control bit 6 is reserved. It always reads back as 0 whatever value is written to it.
- R4: Control bits 5..0 give the number of transactions per burst. Values 1 to 63 give that many transactions, and 0 gives 64.
- R5: `phase_o` encodes idle=0, T1=1, T2=2 and T3=3, and the phases run in that order. T1 lasts 1 plus wait bits 7..5 cycles, T2 lasts 1 plus wait bits 4..3 cycles, and T3 lasts 1 plus wait bits 2..0 cycles.
- R6: `busy_o` is high from the first T1 cycle to the last T3 cycle of a burst. T1 begins in the cycle after the clock edge that samples an accepted request, and each following transaction begins in the cycle right after the previous T3.
- R7: `xact_done_o` is high for exactly one cycle, in the last T3 cycle of every transaction. `rfsh_strobe_o` is high during T2 and T3 only.
- R8: Any number of requests that arrive during a burst are folded into a single pending request. That request starts exactly one further burst after the current burst ends.
- R9: Writes to either register during a burst do not change that burst. The burst size and wait counts are captured when the burst starts.
- R10: When the enable bit is cleared during a burst, the current transaction completes, the sequencer returns to idle, and any pending request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Refresh request, sampled on each rising edge |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 wait |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read-back of the selected register |
| rfsh_strobe_o | output | 1 | Refresh strobe, high in T2 and T3 |
| phase_o | output | 2 | Current phase: 0 idle, 1 T1, 2 T2, 3 T3 |
| busy_o | output | 1 | High while a burst is in progress |
| xact_done_o | output | 1 | One-cycle pulse at the end of each transaction |

## Verification
The assertions assume that `reg_we_i`, `reg_sel_i`, `reg_wdata_i` and `req_i` hold known values at every rising edge. They place no limit on how often requests arrive or when registers are written, so writes and requests during a burst are legal. The stimulus changes every input only at falling edges and always drives it to a defined level. It deliberately writes registers in the middle of a burst and sends extra requests while busy, so that the capture of settings and the single pending flag are both exercised.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_T2   = 2'd2,
    PH_T3   = 2'd3
  } phase_e;

  // wait register layout: T1 count in 7..5, T2 count in 4..3, T3 count in 2..0
  typedef struct packed {
    logic [2:0] w1;
    logic [1:0] w2;
    logic [2:0] w3;
  } waits_t;

  // extra wait cycles for a given phase
  function automatic logic [2:0] phase_wait(input waits_t w, input phase_e p);
    case (p)
      PH_T1:   return w.w1;
      PH_T2:   return {1'b0, w.w2};
      PH_T3:   return w.w3;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rfsh_regs.sv
module rfsh_regs #(
  parameter int DATA_W  = 8,
  parameter int BURST_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic                sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                en,
  output logic [BURST_W-1:0]  size,
  output rfsh_pkg::waits_t    waits
);
  localparam int PAD_W = DATA_W - 1 - BURST_W;

  logic               en_q;
  logic [BURST_W-1:0] size_q;
  logic [DATA_W-1:0]  wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      size_q <= '0;
      wait_q <= '1;
    end else if (we) begin
      if (sel) begin
        wait_q <= wdata;
      end else begin
        en_q   <= wdata[DATA_W-1];
        size_q <= wdata[BURST_W-1:0];
      end
    end
  end

  assign rdata = sel ? wait_q : {en_q, {PAD_W{1'b0}}, size_q};
  assign en    = en_q;
  assign size  = size_q;
  assign waits = rfsh_pkg::waits_t'(wait_q);
endmodule

// File: rtl/rfsh_burst_ctr.sv
module rfsh_burst_ctr #(
  parameter int BURST_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [BURST_W-1:0] size,
  input  logic               dec,
  output logic               last
);
  localparam int CNT_W = BURST_W + 1;

  // a zero field selects the largest burst
  function automatic logic [CNT_W-1:0] burst_len(input logic [BURST_W-1:0] f);
    if (f == '0) return {1'b1, {BURST_W{1'b0}}};
    else         return {1'b0, f};
  endfunction

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem_q <= '0;
    else if (load) rem_q <= burst_len(size);
    else if (dec)  rem_q <= rem_q - CNT_W'(1);
  end

  assign last = (rem_q == CNT_W'(1));
endmodule

// File: rtl/rfsh_phase_fsm.sv
module rfsh_phase_fsm
  import rfsh_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   en,
  input  logic   last,
  input  waits_t waits_in,
  output phase_e phase,
  output logic   xact_end
);
  phase_e     phase_q;
  waits_t     wlat_q;
  logic [2:0] cnt_q;
  logic       ph_over;

  assign ph_over  = (cnt_q == 3'd0);
  assign xact_end = (phase_q == PH_T3) && ph_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wlat_q  <= '0;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_T1;
          wlat_q  <= waits_in;
          cnt_q   <= phase_wait(waits_in, PH_T1);
        end
        PH_T1: if (ph_over) begin
          phase_q <= PH_T2;
          cnt_q   <= phase_wait(wlat_q, PH_T2);
        end else cnt_q <= cnt_q - 3'd1;
        PH_T2: if (ph_over) begin
          phase_q <= PH_T3;
          cnt_q   <= phase_wait(wlat_q, PH_T3);
        end else cnt_q <= cnt_q - 3'd1;
        default: if (ph_over) begin
          if (last || !en) phase_q <= PH_IDLE;
          else begin
            phase_q <= PH_T1;
            cnt_q   <= phase_wait(wlat_q, PH_T1);
          end
        end else cnt_q <= cnt_q - 3'd1;
      endcase
    end
  end

  assign phase = phase_q;
endmodule

// File: rtl/rfsh_burst_seq.sv
module rfsh_burst_seq
  import rfsh_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BURST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rfsh_strobe_o,
  output logic [1:0]        phase_o,
  output logic              busy_o,
  output logic              xact_done_o
);
  logic               en_w;
  logic [BURST_W-1:0] size_w;
  waits_t             waits_w;
  logic               start_w;
  logic               last_w;
  logic               xact_end_w;
  logic               pend_q;
  phase_e             phase_w;
  logic               idle_w;

  rfsh_regs #(.DATA_W(DATA_W), .BURST_W(BURST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .sel(reg_sel_i),
    .wdata(reg_wdata_i), .rdata(reg_rdata_o), .en(en_w),
    .size(size_w), .waits(waits_w)
  );

  rfsh_burst_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(start_w), .size(size_w),
    .dec(xact_end_w), .last(last_w)
  );

  rfsh_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_w), .en(en_w), .last(last_w),
    .waits_in(waits_w), .phase(phase_w), .xact_end(xact_end_w)
  );

  assign idle_w  = (phase_w == PH_IDLE);
  assign start_w = idle_w && en_w && (req_i || pend_q);

  // requests seen during a burst collapse into one flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend_q <= 1'b0;
    else if (!en_w)           pend_q <= 1'b0;
    else if (!idle_w && req_i) pend_q <= 1'b1;
    else if (start_w)         pend_q <= 1'b0;
  end

  assign phase_o       = phase_w;
  assign busy_o        = !idle_w;
  assign xact_done_o   = xact_end_w;
  assign rfsh_strobe_o = (phase_w == PH_T2) || (phase_w == PH_T3);
endmodule

// File: rtl/rfsh_chk.sv
module rfsh_chk
  import rfsh_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_e phase,
  input logic   busy,
  input logic   done,
  input logic   sel,
  input logic   rsv_bit,
  input logic   en
);
  phase_e     prev_q;
  logic [3:0] run_q;
  logic [3:0] cur_run;

  assign cur_run = (phase == prev_q) ? ((run_q == 4'hF) ? run_q : run_q + 4'd1) : 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= PH_IDLE;
      run_q  <= 4'd0;
    end else begin
      prev_q <= phase;
      run_q  <= cur_run;
    end
  end

  always_comb begin
    if (rst_n && !sel) assert_reserved_zero_R3: assert (!rsv_bit);
  end

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && phase == PH_IDLE) |=> (phase == PH_IDLE));

  assert_t1_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1) |-> (cur_run <= 4'd8));
  assert_t2_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2) |-> (cur_run <= 4'd4));
  assert_t3_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T3) |-> (cur_run <= 4'd8));
  assert_order_t1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T1) |=> (phase == PH_T1 || phase == PH_T2));
  assert_order_t2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T2) |=> (phase == PH_T2 || phase == PH_T3));

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase == PH_T1));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && (phase == PH_T1 || phase == PH_IDLE)));
endmodule

bind rfsh_burst_seq rfsh_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase_w), .busy(busy_o),
  .done(xact_done_o), .sel(reg_sel_i), .rsv_bit(reg_rdata_o[6]), .en(en_w)
);

// File: tb/sim_rfsh_burst_seq.sv
`timescale 1ns/1ps
module sim_rfsh_burst_seq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req = 0, we = 0, sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       strobe, busy, done;
  logic [1:0] phase;

  rfsh_burst_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rfsh_strobe_o(strobe),
    .phase_o(phase), .busy_o(busy), .xact_done_o(done)
  );

  always #10 clk = ~clk;

  typedef struct { int t1; int t2; int t3; } xact_t;
  xact_t q[$];

  int n_checks = 0, n_err = 0;
  int c1 = 0, c2 = 0, c3 = 0;
  int done_cnt = 0, busy_cyc = 0, strobe_bad = 0, busy_bad = 0;
  bit prev_done = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (phase == 2'd1) c1++;
    if (phase == 2'd2) c2++;
    if (phase == 2'd3) c3++;
    if (busy) busy_cyc++;
    if (strobe != (phase == 2'd2 || phase == 2'd3)) strobe_bad++;
    if (busy != (phase != 2'd0)) busy_bad++;
    if (done && prev_done) strobe_bad++;
    if (done) begin
      done_cnt++;
      if (q.size() == 0)
        check(0, "R4 unexpected transaction", "extra done", "none");
      else begin
        xact_t e;
        e = q.pop_front();
        check(c1 == e.t1 && c2 == e.t2 && c3 == e.t3, "R5 phase lengths",
              $sformatf("%0d/%0d/%0d", c1, c2, c3),
              $sformatf("%0d/%0d/%0d", e.t1, e.t2, e.t3));
      end
      c1 = 0; c2 = 0; c3 = 0;
    end
    prev_done = done;
  end

  task automatic expect_xacts(input int n, input int w1, input int w2, input int w3);
    for (int i = 0; i < n; i++) begin
      xact_t e;
      e.t1 = w1 + 1; e.t2 = w2 + 1; e.t3 = w3 + 1;
      q.push_back(e);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0; sel = 0;
  endtask

  task automatic rd_check(input logic s, input logic [7:0] exp, input string tag);
    @(negedge clk); sel = s; #1;
    check(rdata == exp, tag, $sformatf("%02h", rdata), $sformatf("%02h", exp));
    sel = 0;
  endtask

  task automatic pulse_req(input bit chk_t1);
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
    if (chk_t1)
      check(phase == 2'd1 && busy, "R6 first T1 after request",
            $sformatf("ph=%0d busy=%0b", phase, busy), "ph=1 busy=1");
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", "timeout", "completion");
      summary();
    end
  end

  initial begin
    int d0, b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(phase == 2'd0 && !busy, "R1 reset idle", $sformatf("ph=%0d busy=%0b", phase, busy), "ph=0 busy=0");
    rd_check(0, 8'h00, "R1 control reset");
    rd_check(1, 8'hFF, "R1 wait reset");

    // R2 disabled: request ignored
    pulse_req(0);
    repeat (10) @(negedge clk);
    check(!busy && done_cnt == 0, "R2 disabled ignores request", $sformatf("busy=%0b done=%0d", busy, done_cnt), "busy=0 done=0");

    // R3 reserved bit
    wr(0, 8'h45);
    rd_check(0, 8'h05, "R3 reserved bit reads zero");

    // R5 reset waits 7/3/7, single transaction
    wr(0, 8'h81);
    expect_xacts(1, 7, 3, 7);
    pulse_req(1);
    wait_idle();
    check(q.size() == 0, "R5 reset waits burst complete", $sformatf("%0d left", q.size()), "0 left");

    // R4/R6 five transactions, zero waits
    wr(1, 8'h00);
    wr(0, 8'h85);
    expect_xacts(5, 0, 0, 0);
    b0 = busy_cyc;
    pulse_req(1);
    wait_idle();
    check(q.size() == 0, "R4 five transactions", $sformatf("%0d left", q.size()), "0 left");
    check(busy_cyc - b0 == 15, "R6 busy span", $sformatf("%0d", busy_cyc - b0), "15");

    // R4 zero field gives 64
    wr(0, 8'h80);
    expect_xacts(64, 0, 0, 0);
    d0 = done_cnt;
    pulse_req(1);
    wait_idle();
    check(done_cnt - d0 == 64, "R4 size zero is 64", $sformatf("%0d", done_cnt - d0), "64");

    // R5 mixed waits 3/2/5
    wr(1, {3'd3, 2'd2, 3'd5});
    wr(0, 8'h82);
    expect_xacts(2, 3, 2, 5);
    pulse_req(1);
    wait_idle();
    check(q.size() == 0, "R5 mixed waits", $sformatf("%0d left", q.size()), "0 left");

    // R8 requests during burst fold into one
    wr(1, 8'h00);
    wr(0, 8'h84);
    expect_xacts(8, 0, 0, 0);
    d0 = done_cnt;
    pulse_req(1);
    repeat (2) @(negedge clk);
    pulse_req(0);
    repeat (2) @(negedge clk);
    pulse_req(0);
    wait_idle();
    check(done_cnt - d0 == 8, "R8 one pending burst", $sformatf("%0d", done_cnt - d0), "8");

    // R9 writes during burst deferred
    wr(0, 8'h83);
    expect_xacts(3, 0, 0, 0);
    pulse_req(1);
    wr(1, 8'hFF);
    wr(0, 8'h85);
    wait_idle();
    check(q.size() == 0, "R9 running burst unchanged", $sformatf("%0d left", q.size()), "0 left");
    expect_xacts(5, 7, 3, 7);
    pulse_req(1);
    wait_idle();
    check(q.size() == 0, "R9 next burst uses new values", $sformatf("%0d left", q.size()), "0 left");

    // R10 disable mid-transaction drops rest and pending
    wr(1, {3'd2, 2'd1, 3'd2});
    wr(0, 8'h8A);
    expect_xacts(1, 2, 1, 2);
    d0 = done_cnt;
    pulse_req(1);
    repeat (2) @(negedge clk);
    pulse_req(0);
    wr(0, 8'h0A);
    repeat (30) @(negedge clk);
    check(!busy && done_cnt - d0 == 1, "R10 disable finishes one transaction",
          $sformatf("busy=%0b done=%0d", busy, done_cnt - d0), "busy=0 done=1");

    check(strobe_bad == 0, "R7 strobe and done pulse shape", $sformatf("%0d", strobe_bad), "0");
    check(busy_bad == 0, "R6 busy tracks phase", $sformatf("%0d", busy_bad), "0");
    finished = 1;
    summary();
  end
endmodule